// File: doc/BRIEF.md
# Multi-Channel Cell Bus Transmit Slave (PHY Side)

This block is the receiving end, on the physical-layer side, of a 16-bit UTOPIA Level 2 style transmit bus. It serves three channels, and each channel answers to a 5-bit bus address that is configured from outside. The ATM-layer master polls a channel by driving that channel's address. On the next clock the channel reports on its own cell-available line whether it has room for a cell. While a channel is not addressed, its cell-available line is not driven. The line is modelled as a data bit with an output-enable beside it.

The master selects a channel in two steps. It drives the channel's address while the active-low enable is high, then pulls the enable low. The selected channel takes one 16-bit word per clock for as long as the enable stays low. A cell is 27 words, and start-of-cell marks the first word. Raising the enable pauses the transfer. Each channel keeps its own position in the cell, so the master can serve other channels in between and resume later. Every word must carry odd parity.

The block strips the filler byte that follows the five header bytes and emits byte writes into a per-channel cell buffer, which sits outside this block. When a cell ends, the block reports it and marks the cell bad if any of its words failed parity. A start-of-cell that arrives in the middle of a cell abandons the partial cell and sets a sticky error flag for that channel. Each channel holds one cell: it has no room after a cell completes, and room returns when the downstream side pulses that channel's consume strobe.

Top module: `utx_phy_slave`

## Requirements
- R1: While reset is held, `clavOe`, `wrEn`, `cellDone` and `socErr` are all zero. After reset, every channel has room, so a poll reports `clavData` = 1.
- R2: The block samples `txAddr` at a clock edge and presents the result after that edge. `clavOe[c]` is 1 exactly when `txAddr` equals channel c's address, which sits in `chanAddr[5c+4:5c]`. `clavData[c]` then gives that channel's room flag. Channels that do not match keep `clavOe` at 0.
- R3: A channel is selected when its address is on `txAddr` in a cycle with `txEnN` = 1 and `txEnN` is 0 in the next cycle. The word present in that next cycle is taken by the selected channel. No word is taken in any cycle with `txEnN` = 1.
- R4: A word taken at an edge produces a write after that edge. `wrMask[1]` writes `wrBytes[15:8]` to byte `wrByteIdx`, and `wrMask[0]` writes `wrBytes[7:0]` to byte `wrByteIdx+1`. Word n < 2 writes bytes 2n and 2n+1 with mask 11. Word 2 writes only byte 4, with mask 10, and its low byte (the filler) is dropped. Word n ≥ 3 writes bytes 2n−1 and 2n with mask 11. `wrChan` names the channel.
- R5: Raising `txEnN` pauses a transfer. A later selection of the same channel resumes at the next word of the cell, even if other channels were served in between.
- R6: A word with `txSoc` = 1 is always taken as word 0. If the channel was partway through a cell, the partial cell is dropped and `socErr[c]` is set. `socErr[c]` stays set until reset.
- R7: Parity is odd over `{txData, txParity}`. `cellBad` is 1 with `cellDone` when any word of that cell had even parity. The parity record clears at each new cell.
- R8: At word 0, a word with `txSoc` = 0 is discarded and produces no write.
- R9: When a cell completes, its channel has no room, and words sent to it are discarded. A one-cycle pulse on `consume[c]` restores room, and polls report it.
- R10: `cellDone` pulses for one cycle, together with the write of the last word (byte 51, mask 11). `cellChan` gives the channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanAddr | input | 15 | Per-channel 5-bit bus address, channel c at [5c+4:5c] |
| txAddr | input | 5 | Address driven by the master |
| txEnN | input | 1 | Active-low transfer enable |
| txSoc | input | 1 | Start-of-cell, high with word 0 |
| txData | input | 16 | Cell word, first byte in [15:8] |
| txParity | input | 1 | Odd parity bit for txData |
| consume | input | 3 | Per-channel pulse that frees the cell buffer |
| clavData | output | 3 | Per-channel cell-available value |
| clavOe | output | 3 | Per-channel drive enable for clavData |
| wrEn | output | 1 | Buffer byte-write valid |
| wrChan | output | 4 | Channel of the buffer write |
| wrByteIdx | output | 6 | Byte index for wrBytes[15:8] |
| wrBytes | output | 16 | Bytes to write |
| wrMask | output | 2 | Byte lanes written |
| cellDone | output | 1 | Cell completed this cycle |
| cellChan | output | 4 | Channel of the completed cell |
| cellBad | output | 1 | Completed cell had a parity error |
| socErr | output | 3 | Sticky mid-cell start-of-cell flags |

## Verification
Every result is due one clock after the edge that samples its stimulus. A poll address driven before an edge shows on `clavOe` and `clavData` after that edge. A word taken at an edge produces its write, `cellDone`, `cellBad` and any `socErr` change after the same edge. A consume pulse is visible on the next poll. The bench drives each stimulus at a falling edge and checks at the following falling edge, so each check sees exactly one rising edge of latency.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int CHAN_W = 4;
  localparam int CELL_WORDS_STD = 27;

  typedef struct packed {
    logic              accept;
    logic [CHAN_W-1:0] chan;
  } utxStrobe_t;
endpackage

// File: rtl/utx_ctrl.sv
module utx_ctrl
  import utx_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH*ADDR_W-1:0] chanAddr,
  input  logic [ADDR_W-1:0]        txAddr,
  input  logic                     txEnN,
  input  logic [NUM_CH-1:0]        cellEnd,
  input  logic [NUM_CH-1:0]        consume,
  output logic [NUM_CH-1:0]        clavData,
  output logic [NUM_CH-1:0]        clavOe,
  output utxStrobe_t               strobe
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              prevEnN;
  logic [ADDR_W-1:0] prevAddr;
  logic              selValid;
  logic [CHAN_W-1:0] selChan;
  logic [NUM_CH-1:0] room, roomNext, matchNow, matchPrev;
  logic              prevHit, startNow, effValid;
  logic [CHAN_W-1:0] prevIdx, effChan;

  for (genvar c = 0; c < NUM_CH; c++) begin : gMatch
    assign matchNow[c]  = (txAddr   == chanAddr[c*ADDR_W +: ADDR_W]);
    assign matchPrev[c] = (prevAddr == chanAddr[c*ADDR_W +: ADDR_W]);
  end

  // lowest channel wins if two share an address
  always_comb begin
    prevHit = 1'b0;
    prevIdx = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (matchPrev[c]) begin
        prevHit = 1'b1;
        prevIdx = CHAN_W'(c);
      end
    end
  end

  always_comb begin
    startNow      = prevEnN & ~txEnN;
    effValid      = startNow ? prevHit : selValid;
    effChan       = startNow ? prevIdx : selChan;
    strobe.chan   = effChan;
    strobe.accept = ~txEnN & effValid & room[effChan[CH_W-1:0]];
    roomNext      = (room | consume) & ~cellEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevEnN  <= 1'b1;
      prevAddr <= '0;
      selValid <= 1'b0;
      selChan  <= '0;
      room     <= '1;
      clavOe   <= '0;
      clavData <= '0;
    end else begin
      prevEnN  <= txEnN;
      prevAddr <= txAddr;
      if (startNow) begin
        selValid <= prevHit;
        selChan  <= prevIdx;
      end
      room     <= roomNext;
      clavOe   <= matchNow;
      clavData <= roomNext;
    end
  end
endmodule

// File: rtl/utx_datapath.sv
module utx_datapath
  import utx_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int DATA_W     = 16,
  parameter int CELL_WORDS = CELL_WORDS_STD
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  utxStrobe_t            strobe,
  input  logic [DATA_W-1:0]     txData,
  input  logic                  txParity,
  input  logic                  txSoc,
  output logic                  wrEn,
  output logic [CHAN_W-1:0]     wrChan,
  output logic [$clog2(2*CELL_WORDS)-1:0] wrByteIdx,
  output logic [DATA_W-1:0]     wrBytes,
  output logic [1:0]            wrMask,
  output logic                  cellDone,
  output logic [CHAN_W-1:0]     cellChan,
  output logic                  cellBad,
  output logic [NUM_CH-1:0]     socErr,
  output logic [NUM_CH-1:0]     cellEnd
);
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int IDX_W    = $clog2(CELL_WORDS);
  localparam int BI_W     = $clog2(2*CELL_WORDS);
  localparam int LAST     = CELL_WORDS - 1;
  localparam int FILL_W   = 2;  // word holding last header byte and filler

  logic [IDX_W-1:0] wordIdx [NUM_CH];
  logic [NUM_CH-1:0] parBad;
  logic [CH_W-1:0]   ch;
  logic [IDX_W-1:0]  curIdx, effIdx;
  logic              wordErr, take, midSoc, isLast, errAcc;

  function automatic logic [BI_W-1:0] byteIdxOf(input logic [IDX_W-1:0] w);
    if (w < IDX_W'(FILL_W))       return BI_W'(w) << 1;
    else if (w == IDX_W'(FILL_W)) return BI_W'(2 * FILL_W);
    else                          return (BI_W'(w) << 1) - BI_W'(1);
  endfunction

  always_comb begin
    ch      = strobe.chan[CH_W-1:0];
    curIdx  = wordIdx[ch];
    wordErr = ~^{txData, txParity};
    take    = strobe.accept & (txSoc | (curIdx != '0));
    midSoc  = strobe.accept & txSoc & (curIdx != '0);
    effIdx  = txSoc ? '0 : curIdx;
    isLast  = take & (effIdx == IDX_W'(LAST));
    errAcc  = (~txSoc & parBad[ch]) | wordErr;
    for (int c = 0; c < NUM_CH; c++)
      cellEnd[c] = isLast & (ch == CH_W'(c));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) wordIdx[c] <= '0;
      parBad <= '0;
      socErr <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (take && ch == CH_W'(c)) begin
          wordIdx[c] <= isLast ? '0 : effIdx + IDX_W'(1);
          parBad[c]  <= ~isLast & errAcc;
        end
        if (midSoc && ch == CH_W'(c)) socErr[c] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn      <= 1'b0;
      wrChan    <= '0;
      wrByteIdx <= '0;
      wrBytes   <= '0;
      wrMask    <= '0;
      cellDone  <= 1'b0;
      cellChan  <= '0;
      cellBad   <= 1'b0;
    end else begin
      wrEn      <= take;
      wrChan    <= strobe.chan;
      wrByteIdx <= byteIdxOf(effIdx);
      wrBytes   <= txData;
      wrMask    <= (effIdx == IDX_W'(FILL_W)) ? 2'b10 : 2'b11;
      cellDone  <= isLast;
      cellChan  <= strobe.chan;
      cellBad   <= errAcc;
    end
  end
endmodule

// File: rtl/utx_phy_slave.sv
module utx_phy_slave
  import utx_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int CELL_WORDS = CELL_WORDS_STD
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH*ADDR_W-1:0] chanAddr,
  input  logic [ADDR_W-1:0]        txAddr,
  input  logic                     txEnN,
  input  logic                     txSoc,
  input  logic [DATA_W-1:0]        txData,
  input  logic                     txParity,
  input  logic [NUM_CH-1:0]        consume,
  output logic [NUM_CH-1:0]        clavData,
  output logic [NUM_CH-1:0]        clavOe,
  output logic                     wrEn,
  output logic [CHAN_W-1:0]        wrChan,
  output logic [$clog2(2*CELL_WORDS)-1:0] wrByteIdx,
  output logic [DATA_W-1:0]        wrBytes,
  output logic [1:0]               wrMask,
  output logic                     cellDone,
  output logic [CHAN_W-1:0]        cellChan,
  output logic                     cellBad,
  output logic [NUM_CH-1:0]        socErr
);
  utxStrobe_t        strobe;
  logic [NUM_CH-1:0] cellEnd;

  utx_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .chanAddr(chanAddr), .txAddr(txAddr),
    .txEnN(txEnN), .cellEnd(cellEnd), .consume(consume),
    .clavData(clavData), .clavOe(clavOe), .strobe(strobe)
  );

  utx_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .txParity(txParity), .txSoc(txSoc), .wrEn(wrEn), .wrChan(wrChan),
    .wrByteIdx(wrByteIdx), .wrBytes(wrBytes), .wrMask(wrMask),
    .cellDone(cellDone), .cellChan(cellChan), .cellBad(cellBad),
    .socErr(socErr), .cellEnd(cellEnd)
  );
endmodule

// File: rtl/utx_phy_slave_chk.sv
module utx_phy_slave_chk #(
  parameter int NUM_CH = 3,
  parameter int BI_W   = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              txEnN,
  input logic              wrEn,
  input logic [BI_W-1:0]   wrByteIdx,
  input logic [1:0]        wrMask,
  input logic              cellDone,
  input logic [NUM_CH-1:0] socErr
);
  // R3: no word is taken while the enable is high
  assert_idle_no_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(txEnN) |-> !wrEn);

  // R4: the single-byte write is always the fifth header byte
  assert_filler_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrMask == 2'b10) |-> (wrByteIdx == BI_W'(4)));

  // R10: a completed cell coincides with the last two-byte write
  assert_done_with_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    cellDone |-> (wrEn && wrMask == 2'b11 && wrByteIdx == BI_W'(51)));

  // R6: error flags never clear outside reset
  assert_soc_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|socErr) |=> ((socErr & $past(socErr)) == $past(socErr)));
endmodule

bind utx_phy_slave utx_phy_slave_chk #(.NUM_CH(NUM_CH), .BI_W($clog2(2*CELL_WORDS))) uChk (
  .clk(clk), .rstN(rstN), .txEnN(txEnN), .wrEn(wrEn), .wrByteIdx(wrByteIdx),
  .wrMask(wrMask), .cellDone(cellDone), .socErr(socErr)
);

// File: tb/utx_phy_slave_test.sv
`timescale 1ns/1ps
module utx_phy_slave_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] chanAddr = {5'd30, 5'd17, 5'd3};
  logic [4:0]  txAddr = 5'd31;
  logic        txEnN = 1'b1, txSoc = 1'b0, txParity = 1'b0;
  logic [15:0] txData = '0;
  logic [2:0]  consume = '0;
  logic [2:0]  clavData, clavOe, socErr;
  logic        wrEn, cellDone, cellBad;
  logic [3:0]  wrChan, cellChan;
  logic [5:0]  wrByteIdx;
  logic [15:0] wrBytes;
  logic [1:0]  wrMask;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  utx_phy_slave uut (
    .clk(clk), .rstN(rstN), .chanAddr(chanAddr), .txAddr(txAddr), .txEnN(txEnN),
    .txSoc(txSoc), .txData(txData), .txParity(txParity), .consume(consume),
    .clavData(clavData), .clavOe(clavOe), .wrEn(wrEn), .wrChan(wrChan),
    .wrByteIdx(wrByteIdx), .wrBytes(wrBytes), .wrMask(wrMask), .cellDone(cellDone),
    .cellChan(cellChan), .cellBad(cellBad), .socErr(socErr)
  );

  // poll vectors: {address, expected clavOe}
  localparam logic [7:0] POLL_VEC [6] = '{
    {5'd3, 3'b001}, {5'd17, 3'b010}, {5'd30, 3'b100},
    {5'd0, 3'b000}, {5'd31, 3'b000}, {5'd17, 3'b010}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] addrOf(input int ch);
    return chanAddr[ch*5 +: 5];
  endfunction

  function automatic int expIdx(input int w);
    if (w < 2) return 2 * w;
    if (w == 2) return 4;
    return 2 * w - 1;
  endfunction

  // drive one cycle of inputs at a falling edge, return at the next falling edge
  task automatic cyc(input bit enN, input logic [4:0] a, input logic [15:0] d,
                     input bit soc, input bit badPar);
    txEnN = enN; txAddr = a; txData = d; txSoc = soc;
    txParity = badPar ? ^d : ~^d;
    @(negedge clk);
  endtask

  task automatic pulseConsume(input int ch);
    consume[ch] = 1'b1;
    @(negedge clk);
    consume = '0;
  endtask

  task automatic sendWords(input int ch, input int first, input int count,
                           input int seed, input int badW, input bit expBad,
                           input bit doSelect);
    if (doSelect) cyc(1'b1, addrOf(ch), 16'h0, 1'b0, 1'b0);
    for (int w = first; w < first + count; w++) begin
      logic [15:0] d;
      d = {8'(seed + 2 * w), 8'(seed + 2 * w + 1)};
      cyc(1'b0, addrOf(ch), d, w == 0, w == badW);
      chk(wrEn == 1'b1, "R3", int'(wrEn), 1);
      chk(wrChan == 4'(ch), "R4", int'(wrChan), ch);
      chk(int'(wrByteIdx) == expIdx(w), "R4", int'(wrByteIdx), expIdx(w));
      chk(wrMask == ((w == 2) ? 2'b10 : 2'b11), "R4", int'(wrMask), (w == 2) ? 2 : 3);
      chk(wrBytes == d, "R4", int'(wrBytes), int'(d));
      if (w == 26) begin
        chk(cellDone == 1'b1, "R10", int'(cellDone), 1);
        chk(cellChan == 4'(ch), "R10", int'(cellChan), ch);
        chk(cellBad == expBad, "R7", int'(cellBad), int'(expBad));
      end else begin
        chk(cellDone == 1'b0, "R10", int'(cellDone), 0);
      end
    end
  endtask

  task automatic poll(input int ch, input bit expRoom, input string req);
    cyc(1'b1, addrOf(ch), 16'h0, 1'b0, 1'b0);
    chk(clavOe == 3'(1 << ch), req, int'(clavOe), 1 << ch);
    chk(clavData[ch] == expRoom, req, int'(clavData[ch]), int'(expRoom));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(clavOe == 3'b000, "R1", int'(clavOe), 0);
    chk(wrEn == 1'b0, "R1", int'(wrEn), 0);
    chk(cellDone == 1'b0, "R1", int'(cellDone), 0);
    chk(socErr == 3'b000, "R1", int'(socErr), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 poll table, room all set after reset (R1)
    foreach (POLL_VEC[i]) begin
      cyc(1'b1, POLL_VEC[i][7:3], 16'h0, 1'b0, 1'b0);
      chk(clavOe == POLL_VEC[i][2:0], "R2", int'(clavOe), int'(POLL_VEC[i][2:0]));
      chk((clavData & clavOe) == clavOe, "R1", int'(clavData & clavOe), int'(clavOe));
    end

    // R3: enable high, no words taken
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, addrOf(1), 16'hABCD, 1'b1, 1'b0);
      chk(wrEn == 1'b0, "R3", int'(wrEn), 0);
    end

    // R4/R10: full good cell on channel 1
    sendWords(1, 0, 27, 8'h10, -1, 1'b0, 1'b1);
    cyc(1'b1, 5'd31, 16'h0, 1'b0, 1'b0);
    // R9: no room after cell, words dropped, consume restores
    poll(1, 1'b0, "R9");
    cyc(1'b0, addrOf(1), 16'h1234, 1'b1, 1'b0);
    chk(wrEn == 1'b0, "R9", int'(wrEn), 0);
    cyc(1'b1, 5'd31, 16'h0, 1'b0, 1'b0);
    pulseConsume(1);
    poll(1, 1'b1, "R9");

    // R7: parity error in word 5 marks cell bad, next cell clean
    sendWords(0, 0, 27, 8'h40, 5, 1'b1, 1'b1);
    pulseConsume(0);
    sendWords(0, 0, 27, 8'h80, -1, 1'b0, 1'b1);
    pulseConsume(0);

    // R5: pause channel 2, serve channel 0, resume channel 2
    sendWords(2, 0, 10, 8'h20, -1, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 5'd31, 16'hFFFF, 1'b0, 1'b0);
      chk(wrEn == 1'b0, "R5", int'(wrEn), 0);
    end
    sendWords(0, 0, 3, 8'h60, -1, 1'b0, 1'b1);
    sendWords(2, 10, 17, 8'h20, -1, 1'b0, 1'b1);

    // R6: start-of-cell in mid cell on channel 1
    sendWords(1, 0, 5, 8'h05, -1, 1'b0, 1'b1);
    chk(socErr == 3'b000, "R6", int'(socErr), 0);
    sendWords(1, 0, 1, 8'h90, -1, 1'b0, 1'b0);
    chk(socErr == 3'b010, "R6", int'(socErr), 2);
    sendWords(1, 1, 26, 8'h90, -1, 1'b0, 1'b0);
    cyc(1'b1, 5'd31, 16'h0, 1'b0, 1'b0);
    chk(socErr == 3'b010, "R6", int'(socErr), 2);

    // R8: word without start-of-cell at word 0 discarded
    pulseConsume(1);
    cyc(1'b1, addrOf(1), 16'h0, 1'b0, 1'b0);
    cyc(1'b0, addrOf(1), 16'h5555, 1'b0, 1'b0);
    chk(wrEn == 1'b0, "R8", int'(wrEn), 0);
    sendWords(1, 0, 27, 8'hC0, -1, 1'b0, 1'b0);
    cyc(1'b1, 5'd31, 16'h0, 1'b0, 1'b0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule